// File: doc/BRIEF.md
# Four-times linear interpolation upsampler

This block raises the rate of a signed sample stream by a fixed factor of four. Each input sample opens a group of four output points. The first three points lie on the straight line from the previous sample to the new one, at one quarter, one half and three quarters of the way. The fourth point is the new sample itself. A typical use is to take a 250 k samples/s source up to 1 M samples/s ahead of a DAC, so that the output moves in steps a quarter of the size of the raw staircase. Because the ratio is a power of two, every point is formed from the difference by shifts and one addition. No multiplier is used.

Both sides are valid/ready streams. An input transfer happens on a clock edge where `in_valid` and `in_ready` are both high. An output transfer happens on an edge where `out_valid` and `out_ready` are both high. `in_ready` is high when no group is pending. It is also high during the cycle in which the last point of the current group is being taken. At all other times it is low, so the upstream side must hold its sample and wait. While `out_valid` is high and `out_ready` is low, the output point stays frozen. After reset, the first input sample has no earlier sample to interpolate from, so its group is four copies of that sample.

Top module: `quad_lerp_upsampler`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the next accepted sample is treated as the first one.
- R2: The first sample accepted after reset produces exactly four output points, each equal to that sample.
- R3: For any later sample x with previous sample p, let d = x - p, computed one bit wider than the data. The block emits four points in this order: p + (d >>> 2), p + (d >>> 1), p + ((3·d) >>> 2), x. Here >>> is an arithmetic right shift, which rounds toward minus infinity.
- R4: Full-scale jumps in either direction between the most negative and the most positive sample values follow R3 exactly, with no wrap-around.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change on the next cycle.
- R6: `in_ready` is 1 only when no group is pending, or when the last point of the current group is transferred in the same cycle. While earlier points of a group are still pending, `in_ready` is 0.
- R7: When the input is offered back-to-back and `out_ready` is held at 1, output points leave on every cycle with no gap. N samples give 4·N points over 4·N consecutive cycles.
- R8: When a sample is accepted while the block is idle, `out_valid` is 1 in the following cycle, and `out_data` then carries the first point of the new group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample is offered |
| in_ready | output | 1 | Block can take the offered sample |
| in_data | input | DATA_W | Signed input sample at the low rate |
| out_valid | output | 1 | Output point is available |
| out_ready | input | 1 | Downstream takes the output point |
| out_data | output | DATA_W | Signed interpolated point at four times the rate |

## Verification
The bench targets the rounding of negative differences. If the three-quarter point were built as a half plus a quarter, or if the division truncated toward zero, points would come out one code high or low. It drives full-scale swings, where a difference held at the data width would wrap and send points to the far rail. It also checks the first sample after reset: a design that interpolated from a stale zero would ramp up from zero instead of holding the value. Random back-pressure and back-to-back input are used to expose lost or repeated points, data that changes while stalled, and a bubble cycle between groups.

// File: rtl/uls_pkg.sv
package uls_pkg;
  localparam int PHASES  = 4;
  localparam int PHASE_W = $clog2(PHASES);
  typedef logic [PHASE_W-1:0] phase_t;
endpackage

// File: rtl/uls_diff.sv
module uls_diff #(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] cur,
  input  logic signed [DATA_W-1:0] prev,
  output logic signed [DATA_W:0]   diff
);
  logic signed [DATA_W:0] cur_x;
  logic signed [DATA_W:0] prev_x;

  // one guard bit keeps full-scale steps from wrapping
  assign cur_x  = {cur[DATA_W-1], cur};
  assign prev_x = {prev[DATA_W-1], prev};
  assign diff   = cur_x - prev_x;
endmodule

// File: rtl/uls_points.sv
module uls_points
  import uls_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic signed [DATA_W-1:0] base,
  input  logic signed [DATA_W:0]   diff,
  input  phase_t                   phase,
  output logic signed [DATA_W-1:0] point
);
  localparam int EW = DATA_W + 3;

  logic signed [EW-1:0] d_ext;
  logic signed [EW-1:0] d_triple;
  logic signed [EW-1:0] base_ext;
  logic signed [EW-1:0] offset;
  logic signed [EW-1:0] sum;

  assign d_ext    = {{2{diff[DATA_W]}}, diff};
  assign d_triple = d_ext + (d_ext <<< 1);
  assign base_ext = {{3{base[DATA_W-1]}}, base};

  always_comb begin
    case (phase)
      phase_t'(0): offset = d_ext >>> 2;
      phase_t'(1): offset = d_ext >>> 1;
      phase_t'(2): offset = d_triple >>> 2;
      default:     offset = d_ext;
    endcase
  end

  assign sum   = base_ext + offset;
  // every point lies between the two samples, so the low bits are exact
  assign point = sum[DATA_W-1:0];
endmodule

// File: rtl/uls_seq.sv
module uls_seq
  import uls_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     in_ready,
  input  logic                     out_ready,
  output logic                     out_valid,
  input  logic signed [DATA_W:0]   diff_in,
  output logic signed [DATA_W-1:0] last_sample,
  output logic signed [DATA_W-1:0] base,
  output logic signed [DATA_W:0]   diff_q,
  output phase_t                   phase
);
  logic busy;
  logic primed;
  logic last_phase;
  logic out_fire;
  logic in_fire;

  assign last_phase = (phase == phase_t'(PHASES - 1));
  assign out_fire   = busy & out_ready;
  assign in_ready   = ~busy | (out_ready & last_phase);
  assign in_fire    = in_valid & in_ready;
  assign out_valid  = busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      primed      <= 1'b0;
      phase       <= '0;
      last_sample <= '0;
      base        <= '0;
      diff_q      <= '0;
    end else if (in_fire) begin
      busy        <= 1'b1;
      primed      <= 1'b1;
      phase       <= '0;
      last_sample <= in_data;
      if (primed) begin
        base   <= last_sample;
        diff_q <= diff_in;
      end else begin
        base   <= in_data;
        diff_q <= '0;
      end
    end else if (out_fire) begin
      if (last_phase) busy <= 1'b0;
      else            phase <= phase + phase_t'(1);
    end
  end
endmodule

// File: rtl/quad_lerp_upsampler.sv
module quad_lerp_upsampler
  import uls_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic signed [DATA_W-1:0] out_data
);
  logic signed [DATA_W:0]   diff_new;
  logic signed [DATA_W:0]   diff_q;
  logic signed [DATA_W-1:0] last_sample;
  logic signed [DATA_W-1:0] base;
  phase_t                   phase;

  uls_diff #(.DATA_W(DATA_W)) u_diff (
    .cur  (in_data),
    .prev (last_sample),
    .diff (diff_new)
  );

  uls_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .out_ready   (out_ready),
    .out_valid   (out_valid),
    .diff_in     (diff_new),
    .last_sample (last_sample),
    .base        (base),
    .diff_q      (diff_q),
    .phase       (phase)
  );

  uls_points #(.DATA_W(DATA_W)) u_points (
    .base  (base),
    .diff  (diff_q),
    .phase (phase),
    .point (out_data)
  );
endmodule

// File: rtl/uls_checker.sv
module uls_checker #(
  parameter int DATA_W = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic signed [DATA_W-1:0] in_data,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic signed [DATA_W-1:0] out_data
);
  logic                     in_fire;
  logic                     out_fire;
  logic [2:0]               pend;
  logic signed [DATA_W-1:0] last_in;

  assign in_fire  = in_valid & in_ready;
  assign out_fire = out_valid & out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      last_in <= '0;
    end else if (in_fire) begin
      pend    <= 3'd4;
      last_in <= in_data;
    end else if (out_fire && pend != 3'd0) begin
      pend <= pend - 3'd1;
    end
  end

  assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && in_ready));

  assert_group_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> (pend == 3'd0 || (pend == 3'd1 && out_fire)));

  assert_last_point_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && pend == 3'd1) |-> (out_data == last_in));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !out_valid) |=> out_valid);
endmodule

bind quad_lerp_upsampler uls_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/quad_lerp_upsampler_test.sv
module quad_lerp_upsampler_test;
  localparam int DW = 16;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic                 out_ready = 1'b1;
  logic signed [DW-1:0] out_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int ready_mode = 0;
  int got[$];
  int got_cyc[$];
  int exp_q[$];
  int m_prev = 0;
  bit m_primed = 1'b0;

  quad_lerp_upsampler #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  always @(negedge clk) if (ready_mode == 1) out_ready = ~out_ready;

  always begin
    @(negedge clk);
    #2;
    if (rst_n && out_valid && out_ready) begin
      got.push_back(int'(out_data));
      got_cyc.push_back(cyc);
    end
  end

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic model(int x);
    int d;
    if (!m_primed) begin
      repeat (4) exp_q.push_back(x);
      m_primed = 1'b1;
    end else begin
      d = x - m_prev;
      exp_q.push_back(m_prev + (d >>> 2));
      exp_q.push_back(m_prev + (d >>> 1));
      exp_q.push_back(m_prev + ((3 * d) >>> 2));
      exp_q.push_back(x);
    end
    m_prev = x;
  endtask

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic send(int x);
    model(x);
    in_valid = 1'b1;
    in_data  = DW'(x);
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain_compare(string req);
    for (int i = 0; i < 400; i++) begin
      if (got.size() >= exp_q.size() && !out_valid) break;
      @(negedge clk);
      #3;
    end
    check({req, " count"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got.size(); i++)
      check(req, got[i], exp_q[i]);
    got.delete();
    got_cyc.delete();
    exp_q.delete();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    out_ready = 1'b1;
    ready_mode = 0;
    m_primed = 1'b0;
    m_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
  endtask

  task automatic t_first();
    send(-1234);
    #1;
    check("R8 out_valid after accept", int'(out_valid), 1);
    check("R8 first point", int'(out_data), -1234);
    check("R6 in_ready mid group", int'(in_ready), 0);
    drain_compare("R2");
  endtask

  task automatic t_ramp();
    send(100);
    send(108);
    send(95);
    send(92);
    send(-7);
    send(-8);
    drain_compare("R3");
  endtask

  task automatic t_full_scale();
    send(-32768);
    send(32767);
    send(-32768);
    send(32767);
    drain_compare("R4");
  endtask

  task automatic t_stall();
    int held;
    out_ready = 1'b0;
    send(5000);
    #1;
    held = int'(out_data);
    repeat (3) @(negedge clk);
    #1;
    check("R5 valid held", int'(out_valid), 1);
    check("R5 data held", int'(out_data), held);
    check("R6 in_ready while stalled", int'(in_ready), 0);
    ready_mode = 1;
    send(-3000);
    send(-2999);
    send(4001);
    drain_compare("R5");
    ready_mode = 0;
    out_ready = 1'b1;
  endtask

  task automatic t_streaming();
    int n0;
    int n1;
    out_ready = 1'b1;
    for (int k = 0; k < 6; k++) send(k * 1000 - 2500);
    for (int i = 0; i < 40; i++) begin
      if (got.size() >= 24 && !out_valid) break;
      @(negedge clk);
      #3;
    end
    check("R7 point count", got.size(), 24);
    if (got_cyc.size() == 24) begin
      n0 = got_cyc[0];
      n1 = got_cyc[23];
      check("R7 span cycles", n1 - n0, 23);
    end
    drain_compare("R7");
  endtask

  initial begin
    t_reset();
    t_first();
    t_ramp();
    t_full_scale();
    t_stall();
    t_streaming();
    t_reset();
    t_first();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule